// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface and walks a freshly powered device from its unknown power-up state to a usable one. After the synchronous reset is released, with the clock already stable, it drives only no-operation commands for a power-up wait that is derived from the clock frequency. It then closes every bank with a single precharge-all, issues two auto-refresh commands, and finally writes the mode register with a word fixed at elaboration time. Each command is followed by NOP cycles for a parameterized wait (row precharge time, refresh cycle time, mode-register set time).

The mode word is validated before it is ever driven. When it holds a reserved CAS-latency code, a non-standard operating mode or a nonzero reserved bit, the sequencer stops in the slot where the load would have gone out and raises an error flag instead of the ready flag. Once either flag is up, it stays up and the command bus carries NOP until the next reset. Clock enable is high throughout.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low and after it is released, the command pins {cs_n, ras_n, cas_n, we_n} carry NOP (0,1,1,1) until the precharge, for at least PWRUP_CYC = CLK_MHZ*PWRUP_US cycles after release and no more than PWRUP_CYC+2.
- R2: Exactly one precharge-all is issued, encoded 0,0,1,0 with address bit AP_BIT (10) high, every other address bit low and the bank bits low.
- R3: Exactly two auto-refresh commands (0,0,0,1) follow; the first appears exactly T_RP cycles after the precharge and the second exactly T_RFC cycles after the first.
- R4: With a valid mode word, one load-mode command (0,0,0,0) appears exactly T_RFC cycles after the second refresh, never before both refreshes, with the address bus equal to MODE_WORD and the bank bits zero.
- R5: Every cycle that is not one of the commands above carries NOP; no other command code ever appears.
- R6: init_done rises exactly T_MRD cycles after the load-mode command, stays high until the next reset, and no command other than NOP is issued while it is high.
- R7: MODE_WORD is valid only when bits 12:10 are 000, bits 8:7 are 00 and bits 6:4 are 010 or 011; otherwise no load-mode command is issued, init_err rises exactly T_RFC cycles after the second refresh and stays high, and init_done never rises.
- R8: init_done and init_err are never high together.
- R9: cke is high in every cycle, in and out of reset.
- R10: A reset applied partway through the sequence returns the pins to NOP with both flags low, and after release the whole sequence restarts with the full power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stable controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (precharge-all flag, mode word) |
| ba | output | BA_W | Bank address |
| init_done | output | 1 | Device initialized and ready |
| init_err | output | 1 | Mode word rejected; sequence halted |

## Verification
The mode-word decision and the load-mode command compete for the same cycle: the end of the second refresh wait either issues the load or enters the error state, never both. Several instances with different mode words (two valid latencies, a reserved latency, a reserved high bit, a non-standard operating mode) run side by side from a shared reset, and for each one the bench judges that exactly one of the two outcomes appears in exactly that slot, T_RFC after the second refresh, and that the two flags never coincide.

// File: rtl/sdram_init_pkg.sv
// Shared types for the SDRAM power-up sequencer.
// Command codes are the packed {cs_n, ras_n, cas_n, we_n} values on the pins.
package sdram_init_pkg;

    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdram_cmd_e;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_PRE,
        ST_WAIT_RP,
        ST_REF1,
        ST_WAIT_RFC1,
        ST_REF2,
        ST_WAIT_RFC2,
        ST_LMR,
        ST_WAIT_MRD,
        ST_READY,
        ST_FAULT
    } init_state_e;

endpackage

// File: rtl/sdram_init_timer.sv
// Loadable down-counter used for every wait of the sequence.
// Assumes: load has priority; counter parks at zero; reset value covers the
// power-up wait so the first state needs no load pulse.
module sdram_init_timer #(
    parameter int CNT_W   = 16,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(RST_VAL);

    logic [CNT_W-1:0] cnt_q;

    // Count down toward zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= RST_CNT;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_mode_check.sv
// Elaboration-time validation of the mode word.
// Assumes: ADDR_W >= 13; CAS latency field at 6:4, operating mode at 8:7,
// reserved bits from 10 up to the top of the address bus.
module sdram_mode_check #(
    parameter int                ADDR_W    = 13,
    parameter logic [ADDR_W-1:0] MODE_WORD = 'h033,
    parameter int                CL_MIN    = 2,
    parameter int                CL_MAX    = 3
) (
    output logic mode_ok
);
    localparam int CL_LO  = 4;
    localparam int CL_HI  = 6;
    localparam int OPM_LO = 7;
    localparam int OPM_HI = 8;
    localparam int RSV_LO = 10;

    localparam logic [CL_HI-CL_LO:0] CL_CODE  = MODE_WORD[CL_HI:CL_LO];
    localparam bit                   CL_GOOD  = (int'(CL_CODE) >= CL_MIN) && (int'(CL_CODE) <= CL_MAX);
    localparam bit                   OPM_GOOD = (MODE_WORD[OPM_HI:OPM_LO] == '0);
    localparam bit                   RSV_GOOD = (MODE_WORD[ADDR_W-1:RSV_LO] == '0);
    localparam bit                   ALL_GOOD = CL_GOOD && OPM_GOOD && RSV_GOOD;

    // Result is fixed for the instance.
    assign mode_ok = ALL_GOOD;
endmodule

// File: rtl/sdram_cmd_drv.sv
// Registered pin driver: maps the sequencer state to command, address and
// flag outputs one cycle later. Assumes NOP with address zero in any state
// that does not issue a command.
module sdram_cmd_drv
    import sdram_init_pkg::*;
#(
    parameter int                ADDR_W    = 13,
    parameter int                BA_W      = 2,
    parameter int                AP_BIT    = 10,
    parameter logic [ADDR_W-1:0] MODE_WORD = 'h033
) (
    input  logic              clk,
    input  logic              rst_n,
    input  init_state_e       state,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done,
    output logic              init_err
);
    localparam logic [ADDR_W-1:0] PRE_ALL_ADDR = ADDR_W'(1) << AP_BIT;

    sdram_cmd_e        cmd_d;
    logic [ADDR_W-1:0] addr_d;

    // Decode the state into the command and address for the next cycle.
    always_comb begin
        cmd_d  = CMD_NOP;
        addr_d = '0;
        unique case (state)
            ST_PRE: begin
                cmd_d  = CMD_PRE;
                addr_d = PRE_ALL_ADDR;
            end
            ST_REF1, ST_REF2: cmd_d = CMD_REF;
            ST_LMR: begin
                cmd_d  = CMD_LMR;
                addr_d = MODE_WORD;
            end
            default: ;
        endcase
    end

    // Register pins and flags; reset parks the bus on NOP with CKE high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
            addr      <= '0;
            ba        <= '0;
            cke       <= 1'b1;
            init_done <= 1'b0;
            init_err  <= 1'b0;
        end else begin
            {cs_n, ras_n, cas_n, we_n} <= cmd_d;
            addr      <= addr_d;
            ba        <= '0;
            cke       <= 1'b1;
            init_done <= (state == ST_READY);
            init_err  <= (state == ST_FAULT);
        end
    end
endmodule

// File: rtl/sdram_init_seq.sv
// Top of the SDRAM power-up sequencer.
// Order: power-up NOP wait, precharge-all, refresh, refresh, mode load, then
// ready. Command spacing equals the timing parameter measured between command
// cycles. Assumes T_RP, T_RFC and T_MRD are at least 2 and the clock is
// stable when reset is released.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int                CLK_MHZ   = 125,
    parameter int                PWRUP_US  = 100,
    parameter int                T_RP      = 3,
    parameter int                T_RFC     = 8,
    parameter int                T_MRD     = 2,
    parameter int                ADDR_W    = 13,
    parameter int                BA_W      = 2,
    parameter int                AP_BIT    = 10,
    parameter logic [ADDR_W-1:0] MODE_WORD = 'h033
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done,
    output logic              init_err
);
    localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;
    localparam int RP_LD     = (T_RP  > 2) ? T_RP  - 2 : 0;
    localparam int RFC_LD    = (T_RFC > 2) ? T_RFC - 2 : 0;
    localparam int MRD_LD    = (T_MRD > 2) ? T_MRD - 2 : 0;
    localparam int MAX_A     = (PWRUP_CYC > RFC_LD) ? PWRUP_CYC : RFC_LD;
    localparam int MAX_B     = (RP_LD > MRD_LD) ? RP_LD : MRD_LD;
    localparam int CNT_MAX   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);

    init_state_e      state_q, state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             mode_ok;

    sdram_init_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (PWRUP_CYC - 1)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sdram_mode_check #(
        .ADDR_W    (ADDR_W),
        .MODE_WORD (MODE_WORD)
    ) mode_chk_i (
        .mode_ok (mode_ok)
    );

    // Next state and timer reload for each step of the sequence.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_PWRUP:     if (tmr_expired) state_d = ST_PRE;
            ST_PRE: begin
                state_d  = ST_WAIT_RP;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RP_LD);
            end
            ST_WAIT_RP:   if (tmr_expired) state_d = ST_REF1;
            ST_REF1: begin
                state_d  = ST_WAIT_RFC1;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RFC_LD);
            end
            ST_WAIT_RFC1: if (tmr_expired) state_d = ST_REF2;
            ST_REF2: begin
                state_d  = ST_WAIT_RFC2;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RFC_LD);
            end
            ST_WAIT_RFC2: if (tmr_expired) state_d = mode_ok ? ST_LMR : ST_FAULT;
            ST_LMR: begin
                state_d  = ST_WAIT_MRD;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(MRD_LD);
            end
            ST_WAIT_MRD:  if (tmr_expired) state_d = ST_READY;
            ST_READY:     state_d = ST_READY;
            ST_FAULT:     state_d = ST_FAULT;
            default:      state_d = ST_PWRUP;
        endcase
    end

    // State register; reset restarts from the power-up wait.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PWRUP;
        else        state_q <= state_d;
    end

    sdram_cmd_drv #(
        .ADDR_W    (ADDR_W),
        .BA_W      (BA_W),
        .AP_BIT    (AP_BIT),
        .MODE_WORD (MODE_WORD)
    ) drv_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state_q),
        .cke       (cke),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .ba        (ba),
        .init_done (init_done),
        .init_err  (init_err)
    );
endmodule

// File: rtl/sdram_init_chk.sv
// Protocol checker for the sequencer, observing only the pins.
// Tracks which commands have been seen since reset to judge ordering.
module sdram_init_chk #(
    parameter int                ADDR_W    = 13,
    parameter int                BA_W      = 2,
    parameter int                AP_BIT    = 10,
    parameter logic [ADDR_W-1:0] MODE_WORD = 'h033
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BA_W-1:0]   ba,
    input logic              init_done,
    input logic              init_err
);
    logic [3:0] cmd;
    logic       is_pre, is_ref, is_lmr, is_nop;
    logic       seen_pre, seen_lmr;
    logic [1:0] ref_cnt;

    assign cmd    = {cs_n, ras_n, cas_n, we_n};
    assign is_pre = (cmd == 4'b0010);
    assign is_ref = (cmd == 4'b0001);
    assign is_lmr = (cmd == 4'b0000);
    assign is_nop = (cmd == 4'b0111);

    // Remember progress through the sequence since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_pre <= 1'b0;
            seen_lmr <= 1'b0;
            ref_cnt  <= '0;
        end else begin
            if (is_pre) seen_pre <= 1'b1;
            if (is_lmr) seen_lmr <= 1'b1;
            if (is_ref && ref_cnt != 2'd3) ref_cnt <= ref_cnt + 1'b1;
        end
    end

    assert_pre_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (addr == (ADDR_W'(1) << AP_BIT)) && (ba == '0));
    assert_ref_after_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> seen_pre);
    assert_lmr_after_refs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_lmr |-> (ref_cnt == 2'd2) && (addr == MODE_WORD) && (ba == '0));
    assert_known_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n || is_pre || is_ref || is_lmr || is_nop);
    assert_gap_after_lmr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_lmr |=> is_nop);
    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    assert_quiet_when_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> is_nop && seen_lmr);
    assert_err_no_lmr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_err |-> !seen_lmr && !is_lmr);
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_err |=> init_err);
    assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_done && init_err));
    assert_cke_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cke);
endmodule

bind sdram_init_seq sdram_init_chk #(
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .AP_BIT    (AP_BIT),
    .MODE_WORD (MODE_WORD)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .ba        (ba),
    .init_done (init_done),
    .init_err  (init_err)
);

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
// Bench: one instance per mode word in a table, all sharing clock and reset.
// A negedge monitor time-stamps every command; checks compare the stamps
// against the requirement spacing.
module sdram_init_seq_tb_top;
    localparam int NV        = 6;
    localparam int CLK_MHZ   = 125;
    localparam int PWRUP_US  = 100;
    localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;
    localparam int T_RP      = 3;
    localparam int T_RFC     = 8;
    localparam int T_MRD     = 2;

    // Stimulus/expectation table: mode word and whether it must be accepted.
    localparam logic [12:0] MODE_TAB [NV] = '{13'h033, 13'h022, 13'h013, 13'h833, 13'h0B3, 13'h043};
    localparam bit          OK_TAB   [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        cke_a [NV];
    logic        cs_a  [NV];
    logic        ras_a [NV];
    logic        cas_a [NV];
    logic        we_a  [NV];
    logic [12:0] addr_a[NV];
    logic [1:0]  ba_a  [NV];
    logic        done_a[NV];
    logic        err_a [NV];

    sdram_init_seq #(
        .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .T_RP(T_RP), .T_RFC(T_RFC),
        .T_MRD(T_MRD), .MODE_WORD(MODE_TAB[0])
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cke(cke_a[0]), .cs_n(cs_a[0]), .ras_n(ras_a[0]),
        .cas_n(cas_a[0]), .we_n(we_a[0]), .addr(addr_a[0]), .ba(ba_a[0]),
        .init_done(done_a[0]), .init_err(err_a[0])
    );

    for (genvar k = 1; k < NV; k++) begin : g_var
        sdram_init_seq #(
            .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .T_RP(T_RP), .T_RFC(T_RFC),
            .T_MRD(T_MRD), .MODE_WORD(MODE_TAB[k])
        ) var_i (
            .clk(clk), .rst_n(rst_n), .cke(cke_a[k]), .cs_n(cs_a[k]), .ras_n(ras_a[k]),
            .cas_n(cas_a[k]), .we_n(we_a[k]), .addr(addr_a[k]), .ba(ba_a[k]),
            .init_done(done_a[k]), .init_err(err_a[k])
        );
    end

    // Monitor records
    int          cyc;
    int          t_pre[NV], t_r1[NV], t_r2[NV], t_lmr[NV], t_done[NV], t_err[NV];
    int          n_pre[NV], n_ref[NV], n_lmr[NV], n_bad[NV], n_cke0[NV], n_both[NV];
    int          n_nop0[NV], n_fall[NV];
    logic [12:0] pre_addr[NV], lmr_addr[NV];
    logic [1:0]  pre_ba[NV], lmr_ba[NV];
    logic        done_prev[NV];

    int tests = 0;
    int fails = 0;

    // Time-stamp commands and flag edges away from the active clock edge.
    always @(negedge clk) begin
        logic [3:0] c;
        if (!rst_n) begin
            cyc = 0;
            for (int k = 0; k < NV; k++) begin
                t_pre[k] = -1; t_r1[k] = -1; t_r2[k] = -1; t_lmr[k] = -1;
                t_done[k] = -1; t_err[k] = -1;
                n_pre[k] = 0; n_ref[k] = 0; n_lmr[k] = 0; n_bad[k] = 0;
                n_cke0[k] = 0; n_both[k] = 0; n_nop0[k] = 0; n_fall[k] = 0;
                done_prev[k] = 1'b0;
            end
        end else begin
            cyc = cyc + 1;
            for (int k = 0; k < NV; k++) begin
                c = {cs_a[k], ras_a[k], cas_a[k], we_a[k]};
                if (c == 4'b0111) begin
                    if (t_pre[k] < 0) n_nop0[k]++;
                end else if (c == 4'b0010) begin
                    if (t_pre[k] < 0) begin t_pre[k] = cyc; pre_addr[k] = addr_a[k]; pre_ba[k] = ba_a[k]; end
                    n_pre[k]++;
                end else if (c == 4'b0001) begin
                    if (n_ref[k] == 0) t_r1[k] = cyc;
                    else if (n_ref[k] == 1) t_r2[k] = cyc;
                    n_ref[k]++;
                end else if (c == 4'b0000) begin
                    if (t_lmr[k] < 0) begin t_lmr[k] = cyc; lmr_addr[k] = addr_a[k]; lmr_ba[k] = ba_a[k]; end
                    n_lmr[k]++;
                end else if (!c[3]) begin
                    n_bad[k]++;
                end
                if (!cke_a[k]) n_cke0[k]++;
                if (done_a[k] && err_a[k]) n_both[k]++;
                if (done_a[k] && t_done[k] < 0) t_done[k] = cyc;
                if (err_a[k] && t_err[k] < 0) t_err[k] = cyc;
                if (done_prev[k] && !done_a[k]) n_fall[k]++;
                done_prev[k] = done_a[k];
            end
        end
    end

    task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit all_finished();
        for (int k = 0; k < NV; k++)
            if (!done_a[k] && !err_a[k]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic wait_finish(input string tag);
        int i;
        for (i = 0; i < PWRUP_CYC + 200 && !all_finished(); i++) @(posedge clk);
        if (!all_finished()) begin
            chk(1'b0, "R1", {"watchdog ", tag}, i, PWRUP_CYC);
            finish_run();
        end
        repeat (3) @(posedge clk);
        #2;
    endtask

    // Walk the table and judge every instance against its expectation.
    task automatic check_table();
        for (int k = 0; k < NV; k++) begin
            chk(t_pre[k] >= PWRUP_CYC && t_pre[k] <= PWRUP_CYC + 2, "R1", "precharge cycle", t_pre[k], PWRUP_CYC);
            chk(n_nop0[k] >= PWRUP_CYC, "R1", "NOPs before precharge", n_nop0[k], PWRUP_CYC);
            chk(n_pre[k] == 1, "R2", "precharge count", n_pre[k], 1);
            chk(pre_addr[k] == 13'h0400 && pre_ba[k] == 2'b00, "R2", "precharge address", int'(pre_addr[k]), 'h400);
            chk(n_ref[k] == 2, "R3", "refresh count", n_ref[k], 2);
            chk(t_r1[k] - t_pre[k] == T_RP, "R3", "precharge to refresh", t_r1[k] - t_pre[k], T_RP);
            chk(t_r2[k] - t_r1[k] == T_RFC, "R3", "refresh to refresh", t_r2[k] - t_r1[k], T_RFC);
            chk(n_bad[k] == 0, "R5", "illegal commands", n_bad[k], 0);
            chk(n_both[k] == 0, "R8", "done and err together", n_both[k], 0);
            chk(n_cke0[k] == 0, "R9", "cke low cycles", n_cke0[k], 0);
            if (OK_TAB[k]) begin
                chk(n_lmr[k] == 1, "R4", "load count", n_lmr[k], 1);
                chk(t_lmr[k] - t_r2[k] == T_RFC, "R4", "refresh to load", t_lmr[k] - t_r2[k], T_RFC);
                chk(lmr_addr[k] == MODE_TAB[k] && lmr_ba[k] == 2'b00, "R4", "load address", int'(lmr_addr[k]), int'(MODE_TAB[k]));
                chk(t_done[k] - t_lmr[k] == T_MRD, "R6", "load to done", t_done[k] - t_lmr[k], T_MRD);
                chk(t_err[k] < 0, "R7", "err on valid word", t_err[k], -1);
            end else begin
                chk(n_lmr[k] == 0, "R7", "load on bad word", n_lmr[k], 0);
                chk(t_err[k] - t_r2[k] == T_RFC, "R7", "refresh to err", t_err[k] - t_r2[k], T_RFC);
                chk(t_done[k] < 0, "R7", "done on bad word", t_done[k], -1);
            end
        end
    endtask

    // Global watchdog: a hung run still reports the summary.
    initial begin
        #(8 * 150000);
        chk(1'b0, "R1", "global watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int cmd_before;
        // R1/R9: pins during reset
        repeat (4) @(posedge clk);
        #2;
        chk({cs_a[0], ras_a[0], cas_a[0], we_a[0]} == 4'b0111, "R1", "cmd in reset",
            int'({cs_a[0], ras_a[0], cas_a[0], we_a[0]}), 7);
        chk(cke_a[0] == 1'b1, "R9", "cke in reset", int'(cke_a[0]), 1);
        chk(!done_a[0] && !err_a[0], "R8", "flags in reset", int'({done_a[0], err_a[0]}), 0);
        @(posedge clk); #1 rst_n = 1'b1;

        wait_finish("first run");
        check_table();

        // R6/R7: flags hold and bus stays quiet after finishing
        cmd_before = n_pre[0] + n_ref[0] + n_lmr[0];
        repeat (40) @(posedge clk);
        #2;
        chk(n_pre[0] + n_ref[0] + n_lmr[0] == cmd_before, "R6", "commands after done",
            n_pre[0] + n_ref[0] + n_lmr[0], cmd_before);
        chk(done_a[0] && n_fall[0] == 0, "R6", "done held", n_fall[0], 0);
        chk(err_a[2] == 1'b1, "R7", "err held", int'(err_a[2]), 1);

        // R10: reset partway through, between the two refreshes
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk); #1 rst_n = 1'b1;
        while (t_r1[0] < 0) @(posedge clk);
        repeat (2) @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk); #2;
        chk({cs_a[0], ras_a[0], cas_a[0], we_a[0]} == 4'b0111, "R10", "cmd after mid reset",
            int'({cs_a[0], ras_a[0], cas_a[0], we_a[0]}), 7);
        chk(!done_a[0] && !err_a[0], "R10", "flags after mid reset", int'({done_a[0], err_a[0]}), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        wait_finish("restart");
        chk(t_pre[0] >= PWRUP_CYC && t_pre[0] <= PWRUP_CYC + 2, "R10", "restart wait", t_pre[0], PWRUP_CYC);
        chk(n_ref[0] == 2 && t_done[0] - t_lmr[0] == T_MRD, "R10", "restart completes", n_ref[0], 2);

        finish_run();
    end
endmodule